// File: doc/BRIEF.md
# Product-Term Cluster Allocator with Stride-Four Expansion Chains

The allocator takes sixteen clusters of five product terms each and produces sixteen logic sums, one per macrocell. By default a cluster's five terms are ORed together and delivered to its own macrocell. To build wider functions, a cluster can instead forward its sum to the macrocell four positions further on. The links form four fixed rings of four macrocells each, and the last member of a ring wraps back to the first. A forwarded sum carries everything that was forwarded into its source, so terms pile up along a run of forwarding members until they reach a member that keeps its sum.

Each cluster has one steering bit. A member that forwards its sum drives ground on its own output. A ring in which all four members forward has nowhere to land its terms. This setting is illegal: the allocator raises a per-ring flag and grounds that ring's outputs. The path is purely combinational and has no clock or state.

Top module: `pt_cluster_alloc`

## Requirements
- R1: With every steering bit at 0, output k equals the OR of product terms 5k through 5k+4.
- R2: Macrocell k belongs to ring (k mod 4). Its forwarding target is macrocell (k+4) mod 16.
- R3: When steering bit k is 1, output k is 0, whatever the terms feeding it.
- R4: The sum a forwarding cluster sends includes every sum forwarded into that cluster. A keeping member therefore outputs the OR of its own cluster and of the unbroken run of forwarding members directly behind it in the ring.
- R5: The ring wraps around. A cluster forwarded from macrocell 12+c lands on macrocell c.
- R6: chain_loop_o[c] is 1 exactly when all four steering bits of ring c are 1. In that case all four outputs of ring c are 0.
- R7: Terms and steering bits of one ring have no effect on the outputs or the loop flag of any other ring.
- R8: A single asserted term out of the five in a cluster is enough to make that cluster's sum 1.
- R9: Outputs follow inputs combinationally, with no clock cycle of delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pt_i | input | 80 | Product terms. Cluster k occupies bits 5k+4:5k |
| steer_i | input | 16 | Steering bit per cluster. 1 forwards the cluster to macrocell (k+4) mod 16 |
| sum_o | output | 16 | Combined logic sum per macrocell |
| chain_loop_o | output | 4 | Per-ring flag for the illegal all-forwarding setting |

## Verification
Two functions can act on the same macrocell in the same evaluation: accumulation along a run of forwarding members, and wrap-around from the top of the ring back to the bottom. The directed tests provoke this by forwarding from macrocells 8 and 12 into macrocell 0 while macrocell 0 keeps its own sum. The expected output is the OR of three clusters, and macrocells 8 and 12 must read 0. Loop detection is provoked with the full-forwarding setting on one ring while a neighbouring ring carries a legal run. The test then checks that only the looping ring is flagged and grounded. Random settings are judged against a model written in the bench that walks each ring backward.

// File: rtl/pt_alloc_pkg.sv
package pt_alloc_pkg;
  localparam int unsigned DEF_N_MC   = 16;
  localparam int unsigned DEF_PT_CL  = 5;
  localparam int unsigned DEF_N_RING = 4;

  // target of a forwarded cluster
  function automatic int unsigned ring_next(int unsigned k, int unsigned n_ring,
                                            int unsigned n_mc);
    return (k + n_ring) % n_mc;
  endfunction
endpackage

// File: rtl/pt_cluster_or.sv
module pt_cluster_or #(
  parameter int unsigned N_CL  = 16,
  parameter int unsigned PT_CL = 5
) (
  input  logic [N_CL*PT_CL-1:0] pt_i,
  output logic [N_CL-1:0]       cl_sum_o
);
  for (genvar g = 0; g < N_CL; g++) begin : g_cl
    assign cl_sum_o[g] = |pt_i[g*PT_CL +: PT_CL];
  end
endmodule

// File: rtl/pt_ring_accum.sv
module pt_ring_accum #(
  parameter int unsigned LEN = 4
) (
  input  logic [LEN-1:0] cl_sum_i,
  input  logic [LEN-1:0] steer_i,
  output logic [LEN-1:0] out_o,
  output logic           loop_o
);
  // unrolled backward walk; never closes the ring, so no comb loop
  always_comb begin
    logic live;
    logic acc;
    out_o = '0;
    for (int k = 0; k < int'(LEN); k++) begin
      live = 1'b1;
      acc  = cl_sum_i[k];
      for (int d = 1; d < int'(LEN); d++) begin
        live = live & steer_i[(k - d + int'(LEN)) % int'(LEN)];
        acc  = acc | (live & cl_sum_i[(k - d + int'(LEN)) % int'(LEN)]);
      end
      out_o[k] = acc & ~steer_i[k];
    end
  end

  assign loop_o = &steer_i;
endmodule

// File: rtl/pt_cluster_alloc.sv
module pt_cluster_alloc
  import pt_alloc_pkg::*;
#(
  parameter int unsigned N_MC   = DEF_N_MC,
  parameter int unsigned PT_CL  = DEF_PT_CL,
  parameter int unsigned N_RING = DEF_N_RING
) (
  input  logic [N_MC*PT_CL-1:0] pt_i,
  input  logic [N_MC-1:0]       steer_i,
  output logic [N_MC-1:0]       sum_o,
  output logic [N_RING-1:0]     chain_loop_o
);
  localparam int unsigned RING_LEN = N_MC / N_RING;

  logic [N_MC-1:0] cl_sum;

  pt_cluster_or #(.N_CL(N_MC), .PT_CL(PT_CL)) u_or (
    .pt_i     (pt_i),
    .cl_sum_o (cl_sum)
  );

  for (genvar c = 0; c < N_RING; c++) begin : g_ring
    logic [RING_LEN-1:0] r_sum, r_steer, r_out;
    for (genvar m = 0; m < RING_LEN; m++) begin : g_mem
      assign r_sum[m]           = cl_sum[c + m*N_RING];
      assign r_steer[m]         = steer_i[c + m*N_RING];
      assign sum_o[c + m*N_RING] = r_out[m];
    end
    pt_ring_accum #(.LEN(RING_LEN)) u_ring (
      .cl_sum_i (r_sum),
      .steer_i  (r_steer),
      .out_o    (r_out),
      .loop_o   (chain_loop_o[c])
    );
  end
endmodule

// File: rtl/pt_cluster_alloc_chk.sv
module pt_cluster_alloc_chk
  import pt_alloc_pkg::*;
#(
  parameter int unsigned N_MC   = 16,
  parameter int unsigned PT_CL  = 5,
  parameter int unsigned N_RING = 4
) (
  input logic [N_MC*PT_CL-1:0] pt_i,
  input logic [N_MC-1:0]       steer_i,
  input logic [N_MC-1:0]       sum_o,
  input logic [N_RING-1:0]     chain_loop_o
);
  always_comb begin
    for (int k = 0; k < int'(N_MC); k++) begin
      // R3 forwarding member is grounded
      assert_steered_ground_R3: assert (!(steer_i[k] && sum_o[k]))
        else $error("R3 steered output %0d not ground", k);
      // R1 isolated keeping member shows its own cluster
      if (!steer_i[k] && !steer_i[(k + N_MC - N_RING) % N_MC])
        assert_local_sum_R1: assert (sum_o[k] == |pt_i[k*PT_CL +: PT_CL])
          else $error("R1 local sum mismatch at %0d", k);
      // R4 R5 forwarded cluster reaches a keeping target
      if (steer_i[k] && !steer_i[ring_next(k, N_RING, N_MC)] && (|pt_i[k*PT_CL +: PT_CL]))
        assert_forward_lands_R4: assert (sum_o[ring_next(k, N_RING, N_MC)])
          else $error("R4 forwarded cluster %0d lost", k);
    end
    for (int c = 0; c < int'(N_RING); c++) begin
      logic all_fwd;
      logic any_out;
      all_fwd = 1'b1;
      any_out = 1'b0;
      for (int m = 0; m < int'(N_MC / N_RING); m++) begin
        all_fwd = all_fwd & steer_i[c + m*N_RING];
        any_out = any_out | sum_o[c + m*N_RING];
      end
      assert_loop_flag_R6: assert (chain_loop_o[c] == all_fwd)
        else $error("R6 loop flag ring %0d", c);
      assert_loop_ground_R6: assert (!(chain_loop_o[c] && any_out))
        else $error("R6 looping ring %0d not grounded", c);
    end
  end
endmodule

bind pt_cluster_alloc pt_cluster_alloc_chk #(
  .N_MC(N_MC), .PT_CL(PT_CL), .N_RING(N_RING)
) u_chk (
  .pt_i         (pt_i),
  .steer_i      (steer_i),
  .sum_o        (sum_o),
  .chain_loop_o (chain_loop_o)
);

// File: tb/pt_cluster_alloc_tb.sv
module pt_cluster_alloc_tb;
  localparam int NMC = 16;
  localparam int PTC = 5;
  localparam int NR  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NMC*PTC-1:0] pt = '0;
  logic [NMC-1:0]     steer = '0;
  logic [NMC-1:0]     sum;
  logic [NR-1:0]      loopf;
  int total = 0;
  int bad = 0;
  bit wd_hit = 1'b0;

  always #4 clk = ~clk;

  pt_cluster_alloc u_dut (
    .pt_i (pt), .steer_i (steer), .sum_o (sum), .chain_loop_o (loopf)
  );

  function automatic logic cl(input logic [NMC*PTC-1:0] p, input int k);
    return |p[k*PTC +: PTC];
  endfunction

  // independent model: walk back from each keeping member
  function automatic logic [NMC-1:0] model_sum(input logic [NMC*PTC-1:0] p,
                                               input logic [NMC-1:0] s);
    logic [NMC-1:0] r = '0;
    for (int k = 0; k < NMC; k++) begin
      if (!s[k]) begin
        int j = k;
        r[k] = cl(p, k);
        for (int n = 0; n < NMC/NR - 1; n++) begin
          j = (j + NMC - NR) % NMC;
          if (!s[j]) break;
          r[k] = r[k] | cl(p, j);
        end
      end
    end
    return r;
  endfunction

  function automatic logic [NR-1:0] model_loop(input logic [NMC-1:0] s);
    logic [NR-1:0] r;
    for (int c = 0; c < NR; c++)
      r[c] = s[c] & s[c+4] & s[c+8] & s[c+12];
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [NMC*PTC-1:0] p, input logic [NMC-1:0] s);
    @(posedge clk);
    pt = p;
    steer = s;
    @(negedge clk);
  endtask

  task automatic t_reset;
    apply('0, '0);
    chk("R1 zero terms", 32'(sum), 32'h0);
    chk("R6 no loop at rest", 32'(loopf), 32'h0);
  endtask

  task automatic t_default;
    logic [NMC*PTC-1:0] p = '0;
    logic [NMC-1:0] e = '0;
    for (int k = 0; k < NMC; k += 3) begin
      p[k*PTC + (k % PTC)] = 1'b1;
      e[k] = 1'b1;
    end
    apply(p, '0);
    chk("R1 default local sums", 32'(sum), 32'(e));
    for (int t = 0; t < PTC; t++) begin
      p = '0;
      p[7*PTC + t] = 1'b1;
      apply(p, '0);
      chk("R8 single term lights cluster 7", 32'(sum), 32'h0080);
    end
  endtask

  task automatic t_step;
    logic [NMC*PTC-1:0] p = '0;
    p[1*PTC] = 1'b1;
    apply(p, 16'h0002);
    chk("R2 R3 M1 forwards to M5", 32'(sum), 32'h0020);
    p = '0;
    p[6*PTC + 2] = 1'b1;
    p[10*PTC + 4] = 1'b1;
    apply(p, 16'h0040);
    chk("R2 M6 into M10", 32'(sum), 32'h0400);
  endtask

  task automatic t_accum_wrap;
    logic [NMC*PTC-1:0] p = '0;
    p[8*PTC] = 1'b1;
    apply(p, 16'h1100);
    chk("R4 R5 M8 via M12 wraps to M0", 32'(sum), 32'h0001);
    p = '0;
    p[8*PTC] = 1'b1;
    p[12*PTC + 3] = 1'b1;
    p[0] = 1'b1;
    apply(p, 16'h1100);
    chk("R4 R5 three clusters on M0", 32'(sum), 32'h0001);
    p = '0;
    p[15*PTC + 1] = 1'b1;
    apply(p, 16'h8000);
    chk("R5 M15 wraps to M3", 32'(sum), 32'h0008);
    p = '0;
    p[4*PTC] = 1'b1;
    apply(p, 16'h0110);
    chk("R4 M4 via M8 reaches M12", 32'(sum), 32'h1000);
  endtask

  task automatic t_loop;
    logic [NMC*PTC-1:0] p = '1;
    apply(p, 16'h2222);
    chk("R6 ring 1 flagged", 32'(loopf), 32'h2);
    chk("R6 R7 ring 1 grounded others local", 32'(sum), 32'hDDDD);
    apply(p, 16'hFFFF);
    chk("R6 all rings flagged", 32'(loopf), 32'hF);
    chk("R6 all grounded", 32'(sum), 32'h0);
    apply(p, 16'h0111);
    chk("R6 three of four no flag", 32'(loopf), 32'h0);
  endtask

  task automatic t_isolate;
    logic [NMC*PTC-1:0] p = '0;
    for (int m = 0; m < 4; m++) p[(2 + 4*m)*PTC] = 1'b1;
    apply(p, 16'h4444);
    chk("R7 other rings dark", 32'(sum & 16'hBBBB), 32'h0);
    chk("R7 only ring 2 flagged", 32'(loopf), 32'h4);
  endtask

  task automatic t_comb;
    logic [NMC*PTC-1:0] p = '0;
    @(negedge clk);
    p[9*PTC] = 1'b1;
    pt = p;
    steer = '0;
    #1;
    chk("R9 same-cycle response", 32'(sum), 32'h0200);
  endtask

  task automatic t_random;
    int unsigned seed = 32'h5eed;
    for (int i = 0; i < 300; i++) begin
      logic [NMC*PTC-1:0] p;
      logic [NMC-1:0] s;
      for (int w = 0; w < NMC*PTC; w++) p[w] = ($urandom(seed + i*97 + w) % 7) == 0;
      s = 16'($urandom(seed + i));
      apply(p, s);
      chk("R4 random sums", 32'(sum), 32'(model_sum(p, s)));
      chk("R6 random loop", 32'(loopf), 32'(model_loop(s)));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    wd_hit = 1'b1;
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset();
    t_default();
    t_step();
    t_accum_wrap();
    t_loop();
    t_isolate();
    t_comb();
    t_random();
    if (!wd_hit) begin
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule